// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is a control unit that carries one instruction at a time through a fixed series of phases. It fetches the instruction, decodes it, forms an address for each operand, optionally follows a pointer, reads each operand, operates on the data, writes each result and then checks for an interrupt. Every memory access goes through an address register and a buffer register. The memory side is a single word-wide port with a request/acknowledge handshake, so the controller waits as long as the memory needs.

The controller keeps a program counter, an instruction register and an accumulator. It also keeps a status word with arithmetic flags, a compare bit, an interrupt enable and a supervisor bit. A small set of opcodes covers every path: single and dual operands, a stored result, pointer indirection, jumps and interrupt enable control. When the interrupt line is high at the end of an instruction and interrupts are enabled, the controller pushes the return address to a fixed stack word and loads the program counter from a fixed vector word.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While reset is high and after it falls, the state is as follows until the first edge: PC equals RESET_PC, the accumulator is 0, the status word is all zero and neither mem_req nor instr_done is asserted.
- R2: Each instruction starts by copying PC into the address register and reading that word. PC then increments by one and the word moves to the instruction register; ir_o shows it when instr_done is high.
- R3: In a memory phase mem_req stays high, and mem_addr, mem_we and mem_wdata stay unchanged, until the cycle in which mem_ack is high. An access whose acknowledge arrives W cycles after the first possible cycle lasts 2+W cycles.
- R4: Instruction word layout: bits [15:12] hold the opcode, bit 11 selects indirection and bits [ADDR_W-1:0] hold the address field. Opcodes: 0 no-op, 1 load, 2 add, 3 store, 4 dual-add, 5 compare, 6 jump (PC takes the field and indirection is ignored), 7 enable interrupts, 8 disable interrupts. Codes 9 to 15 act as no-ops.
- R5: With bit 11 set, each operand or result address field+k is first read as a pointer. Its low ADDR_W bits become the effective address.
- R6: Dual-add reads operands at field+0 and field+1, each with its own address phase. It places their sum in the accumulator and writes it to field+2. Store writes the accumulator to field+0.
- R7: Status bit 0 (zero), bit 1 (sign), bit 2 (carry) and bit 3 (overflow) change only in the execute phase. Load, add and dual-add set them from an unsigned (DATA_W+1)-bit sum; load adds to zero.
- R8: Compare sets status bit 4 to 1 when the accumulator equals the operand and to 0 when it does not. It leaves the accumulator and bits 0 to 3 unchanged.
- R9: If irq is high in the interrupt-check cycle and status bit 5 is 1, the controller writes PC to STACK_ADDR and loads PC from the low bits of the word at VEC_ADDR. It then clears bit 5 and sets bit 6 (supervisor), which adds 3 + 2 memory accesses of cycles before the next fetch.
- R10: With status bit 5 at 0, irq has no effect and the next instruction is fetched from PC. Opcode 7 sets bit 5 and opcode 8 clears it.
- R11: instr_done is high for exactly one cycle per instruction, with no memory request. An instruction takes 5 cycles, plus 1 for each operand or result, plus 1 more for each indirect operand or result, plus the cost of its memory accesses. There is one access for the fetch, one per operand or result, and one more per pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address, taken from the address register |
| mem_wdata | output | DATA_W | Write data, taken from the buffer register |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| irq | input | 1 | Interrupt request level |
| instr_done | output | 1 | Interrupt-check cycle at the end of an instruction |
| pc_o | output | ADDR_W | Program counter |
| ir_o | output | DATA_W | Instruction register |
| acc_o | output | DATA_W | Accumulator |
| status_o | output | 7 | Status: 0 zero, 1 sign, 2 carry, 3 overflow, 4 compare, 5 interrupt enable, 6 supervisor |

## Verification
PC, the accumulator, the status word and the instruction register are all settled in the single cycle where instr_done is high, so the bench compares them there against an instruction-level model. It samples on the falling edge, after all register updates. The length of each instruction is the number of cycles between successive instr_done pulses. The bench computes it from the opcode, the indirect bit and the memory wait it programs into its memory model. It adds the interrupt sequence's cycles to the interval that follows a taken interrupt. The memory wait changes only in an instr_done cycle, when no access is in flight, so each expected length uses a single known wait.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int OPC_W   = 4;
    localparam int OPS_MAX = 2;
    localparam int ST_W    = 7;

    localparam logic [OPC_W-1:0] OPC_NOP  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LDA  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_STA  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_SUM2 = 4'd4;
    localparam logic [OPC_W-1:0] OPC_CMP  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_EI   = 4'd7;
    localparam logic [OPC_W-1:0] OPC_DI   = 4'd8;

    typedef enum logic [2:0] {
        ALU_NONE,
        ALU_LOAD,
        ALU_ADD,
        ALU_SUM,
        ALU_CMP
    } alu_kind_e;

    typedef struct packed {
        logic sup;
        logic ie;
        logic cmp;
        logic ovf;
        logic cry;
        logic sgn;
        logic zro;
    } status_t;

    typedef struct packed {
        logic [1:0] n_ops;
        logic [1:0] n_res;
        alu_kind_e  alu;
        logic       jump;
        logic       ie_set;
        logic       ie_clr;
    } op_plan_t;

    typedef enum logic [4:0] {
        S_FETCH_A,
        S_FETCH_M,
        S_FETCH_IR,
        S_DECODE,
        S_OP_ADDR,
        S_IND_M,
        S_IND_X,
        S_OP_RD,
        S_EXEC,
        S_RES_ADDR,
        S_RES_WR,
        S_INT_CHK,
        S_INT_A,
        S_INT_W,
        S_INT_V,
        S_INT_R,
        S_INT_J
    } cyc_state_e;

    function automatic op_plan_t plan_of(input logic [OPC_W-1:0] opc);
        op_plan_t p;
        p = '{n_ops: 2'd0, n_res: 2'd0, alu: ALU_NONE,
              jump: 1'b0, ie_set: 1'b0, ie_clr: 1'b0};
        case (opc)
            OPC_LDA:  begin p.n_ops = 2'd1; p.alu = ALU_LOAD; end
            OPC_ADD:  begin p.n_ops = 2'd1; p.alu = ALU_ADD;  end
            OPC_STA:  begin p.n_res = 2'd1; end
            OPC_SUM2: begin p.n_ops = 2'd2; p.n_res = 2'd1; p.alu = ALU_SUM; end
            OPC_CMP:  begin p.n_ops = 2'd1; p.alu = ALU_CMP;  end
            OPC_JMP:  p.jump   = 1'b1;
            OPC_EI:   p.ie_set = 1'b1;
            OPC_DI:   p.ie_clr = 1'b1;
            default:  p.alu    = ALU_NONE;
        endcase
        return p;
    endfunction

    function automatic logic is_mem_state(input cyc_state_e s);
        return (s == S_FETCH_M) || (s == S_IND_M) || (s == S_OP_RD) ||
               (s == S_RES_WR)  || (s == S_INT_W) || (s == S_INT_R);
    endfunction

    function automatic logic is_write_state(input cyc_state_e s);
        return (s == S_RES_WR) || (s == S_INT_W);
    endfunction

endpackage

// File: rtl/icc_decoder.sv
module icc_decoder
    import icc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic [DATA_W-1:0] instr,
    output op_plan_t          plan,
    output logic              indirect,
    output logic [ADDR_W-1:0] field
);
    localparam int IND_BIT = DATA_W - OPC_W - 1;

    logic unused_gap;

    assign plan       = plan_of(instr[DATA_W-1 -: OPC_W]);
    assign indirect   = instr[IND_BIT];
    assign field      = instr[ADDR_W-1:0];
    assign unused_gap = ^instr[IND_BIT-1:ADDR_W];

endmodule

// File: rtl/icc_alu.sv
module icc_alu
    import icc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_kind_e         kind,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  status_t           st_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_we,
    output status_t           st_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic [DATA_W:0]   wide;

    always_comb begin
        unique case (kind)
            ALU_ADD: lhs = acc;
            ALU_SUM: lhs = opa;
            default: lhs = '0;
        endcase
        rhs  = (kind == ALU_SUM) ? opb : opa;
        wide = {1'b0, lhs} + {1'b0, rhs};
    end

    always_comb begin
        st_out  = st_in;
        acc_out = wide[MSB:0];
        acc_we  = 1'b0;
        unique case (kind)
            ALU_LOAD, ALU_ADD, ALU_SUM: begin
                acc_we     = 1'b1;
                st_out.zro = (wide[MSB:0] == '0);
                st_out.sgn = wide[MSB];
                st_out.cry = wide[DATA_W];
                st_out.ovf = (lhs[MSB] == rhs[MSB]) && (wide[MSB] != lhs[MSB]);
            end
            ALU_CMP: st_out.cmp = (acc == opa);
            default: st_out = st_in;
        endcase
    end

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
    import icc_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STACK_ADDR = '1,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = '1 - 1'b1,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              irq,
    output logic              instr_done,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [ST_W-1:0]   status_o
);
    localparam int IDX_W = 2;

    cyc_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] acc_q;
    status_t           st_q;
    logic [IDX_W-1:0]  idx_q;
    logic              res_ph_q;
    logic [DATA_W-1:0] opnd_q [OPS_MAX];

    op_plan_t          plan;
    logic              indirect;
    logic [ADDR_W-1:0] field;
    logic [DATA_W-1:0] alu_acc;
    logic              alu_we;
    status_t           alu_st;
    status_t           st_exec;
    logic [ADDR_W-1:0] op_ea;
    logic [ADDR_W-1:0] res_ea;
    logic [IDX_W-1:0]  idx_nx;

    icc_decoder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .instr   (ir_q),
        .plan    (plan),
        .indirect(indirect),
        .field   (field)
    );

    icc_alu #(.DATA_W(DATA_W)) u_alu (
        .kind   (plan.alu),
        .acc    (acc_q),
        .opa    (opnd_q[0]),
        .opb    (opnd_q[1]),
        .st_in  (st_q),
        .acc_out(alu_acc),
        .acc_we (alu_we),
        .st_out (alu_st)
    );

    always_comb begin
        st_exec = alu_st;
        if (plan.ie_set) st_exec.ie = 1'b1;
        if (plan.ie_clr) st_exec.ie = 1'b0;
    end

    assign idx_nx = idx_q + 1'b1;
    assign op_ea  = field + ADDR_W'(idx_q);
    assign res_ea = field + ADDR_W'(plan.n_ops) + ADDR_W'(idx_q);

    // Operand holding registers, one per operand slot.
    for (genvar g = 0; g < OPS_MAX; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (rst)
                opnd_q[g] <= '0;
            else if (state_q == S_OP_RD && mem_ack && idx_q == IDX_W'(g))
                opnd_q[g] <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_FETCH_A;
            pc_q     <= RESET_PC;
            ir_q     <= '0;
            mar_q    <= '0;
            mbr_q    <= '0;
            acc_q    <= '0;
            st_q     <= '0;
            idx_q    <= '0;
            res_ph_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_FETCH_A: begin
                    mar_q   <= pc_q;
                    state_q <= S_FETCH_M;
                end
                S_FETCH_M: if (mem_ack) begin
                    mbr_q   <= mem_rdata;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= S_FETCH_IR;
                end
                S_FETCH_IR: begin
                    ir_q    <= mbr_q;
                    state_q <= S_DECODE;
                end
                S_DECODE: begin
                    idx_q    <= '0;
                    res_ph_q <= 1'b0;
                    state_q  <= (plan.n_ops != '0) ? S_OP_ADDR : S_EXEC;
                end
                S_OP_ADDR: begin
                    mar_q   <= op_ea;
                    state_q <= indirect ? S_IND_M : S_OP_RD;
                end
                S_IND_M: if (mem_ack) begin
                    mbr_q   <= mem_rdata;
                    state_q <= S_IND_X;
                end
                S_IND_X: begin
                    mar_q <= mbr_q[ADDR_W-1:0];
                    if (res_ph_q) begin
                        mbr_q   <= acc_q;
                        state_q <= S_RES_WR;
                    end else begin
                        state_q <= S_OP_RD;
                    end
                end
                S_OP_RD: if (mem_ack) begin
                    mbr_q   <= mem_rdata;
                    idx_q   <= idx_nx;
                    state_q <= (idx_nx == plan.n_ops) ? S_EXEC : S_OP_ADDR;
                end
                S_EXEC: begin
                    if (alu_we) acc_q <= alu_acc;
                    st_q     <= st_exec;
                    if (plan.jump) pc_q <= field;
                    idx_q    <= '0;
                    res_ph_q <= 1'b1;
                    state_q  <= (plan.n_res != '0) ? S_RES_ADDR : S_INT_CHK;
                end
                S_RES_ADDR: begin
                    mar_q   <= res_ea;
                    mbr_q   <= acc_q;
                    state_q <= indirect ? S_IND_M : S_RES_WR;
                end
                S_RES_WR: if (mem_ack) begin
                    idx_q   <= idx_nx;
                    state_q <= (idx_nx == plan.n_res) ? S_INT_CHK : S_RES_ADDR;
                end
                S_INT_CHK: begin
                    state_q <= (irq && st_q.ie) ? S_INT_A : S_FETCH_A;
                end
                S_INT_A: begin
                    mar_q   <= STACK_ADDR;
                    mbr_q   <= DATA_W'(pc_q);
                    state_q <= S_INT_W;
                end
                S_INT_W: if (mem_ack) begin
                    state_q <= S_INT_V;
                end
                S_INT_V: begin
                    mar_q   <= VEC_ADDR;
                    state_q <= S_INT_R;
                end
                S_INT_R: if (mem_ack) begin
                    mbr_q   <= mem_rdata;
                    state_q <= S_INT_J;
                end
                S_INT_J: begin
                    pc_q    <= mbr_q[ADDR_W-1:0];
                    st_q.ie <= 1'b0;
                    st_q.sup <= 1'b1;
                    state_q <= S_FETCH_A;
                end
                default: state_q <= S_FETCH_A;
            endcase
        end
    end

    assign mem_req    = is_mem_state(state_q);
    assign mem_we     = is_write_state(state_q);
    assign mem_addr   = mar_q;
    assign mem_wdata  = mbr_q;
    assign instr_done = (state_q == S_INT_CHK);
    assign pc_o       = pc_q;
    assign ir_o       = ir_q;
    assign acc_o      = acc_q;
    assign status_o   = st_q;

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              instr_done,
    input logic [6:0]        status,
    input logic [DATA_W-1:0] ir,
    input logic              in_exec,
    input logic              in_fetch_ir
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R3

    AST_FLAGS_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(status[3:0])); // R7

    AST_CMP_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(status[4])); // R8

    AST_IR_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
        !in_fetch_ir |=> $stable(ir)); // R2

    AST_INT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(status[6]) |-> !status[5]); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> !mem_req); // R11

endmodule

bind instr_cycle_ctrl icc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .instr_done (instr_done),
    .status     (status_o),
    .ir         (ir_o),
    .in_exec    (state_q == icc_pkg::S_EXEC),
    .in_fetch_ir(state_q == icc_pkg::S_FETCH_IR)
);

// File: tb/instr_cycle_ctrl_tb.sv
module instr_cycle_ctrl_tb;
    localparam int         DW   = 16;
    localparam int         AW   = 8;
    localparam logic [7:0] STK  = 8'hFF;
    localparam logic [7:0] VEC  = 8'hFE;
    localparam int         NINS = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq = 1'b0;
    logic          mem_req, mem_we, mem_ack, instr_done;
    logic [AW-1:0] mem_addr, pc_o;
    logic [DW-1:0] mem_wdata, mem_rdata, ir_o, acc_o;
    logic [6:0]    status_o;

    logic [DW-1:0] mem      [256];
    logic [DW-1:0] init_mem [256];
    logic [DW-1:0] ref_mem  [256];
    int            wait_cycles = 0;
    int            wcnt = 0;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  r_pc;
    logic [15:0] r_acc;
    logic [6:0]  r_st;
    bit          prev_taken, prev_ignored;

    always #5 clk = ~clk;

    instr_cycle_ctrl #(.DATA_W(DW), .ADDR_W(AW), .STACK_ADDR(STK),
                       .VEC_ADDR(VEC), .RESET_PC(8'h00)) u_dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq(irq), .instr_done(instr_done), .pc_o(pc_o),
        .ir_o(ir_o), .acc_o(acc_o), .status_o(status_o)
    );

    // Memory model: acknowledge after wait_cycles extra cycles.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= init_mem[i];
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= wait_cycles) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata     <= mem[mem_addr];
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic ind, input logic [7:0] a);
        return {op, ind, 3'b000, a};
    endfunction

    task automatic put(input logic [7:0] a, input logic [15:0] v);
        init_mem[a] = v;
        ref_mem[a]  = v;
    endtask

    function automatic logic [7:0] ea(input logic [7:0] f, input logic ind, input int k);
        logic [7:0] a;
        a = f + 8'(k);
        return ind ? ref_mem[a][7:0] : a;
    endfunction

    task automatic r_sum(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] w;
        w     = {1'b0, a} + {1'b0, b};
        r_acc = w[15:0];
        r_st[0] = (w[15:0] == 16'h0);
        r_st[1] = w[15];
        r_st[2] = w[16];
        r_st[3] = (a[15] == b[15]) && (w[15] != a[15]);
    endtask

    // Instruction-level reference: returns cycle length and check tags.
    task automatic ref_exec(output int len, output logic [15:0] word,
                            output string t_acc, output string t_st, output string t_pc);
        logic [3:0] op;
        logic       ind;
        logic [7:0] f;
        int         nops, nres;
        word  = ref_mem[r_pc];
        r_pc  = r_pc + 8'd1;
        op    = word[15:12];
        ind   = word[11];
        f     = word[7:0];
        nops  = 0;
        nres  = 0;
        t_acc = ind ? "R5 indirect" : "R7 acc";
        t_st  = "R7 flags";
        t_pc  = prev_taken ? "R9 vector" : (prev_ignored ? "R10 irq ignored" : "R2 pc step");
        case (op)
            4'd1: begin nops = 1; r_sum(16'h0, ref_mem[ea(f, ind, 0)]); end
            4'd2: begin nops = 1; r_sum(r_acc, ref_mem[ea(f, ind, 0)]); end
            4'd3: begin nres = 1; ref_mem[ea(f, ind, 0)] = r_acc; t_acc = "R6 store"; end
            4'd4: begin
                nops = 2; nres = 1;
                r_sum(ref_mem[ea(f, ind, 0)], ref_mem[ea(f, ind, 1)]);
                ref_mem[ea(f, ind, 2)] = r_acc;
                t_acc = ind ? "R5 dual-add indirect" : "R6 dual-add";
            end
            4'd5: begin
                nops = 1;
                r_st[4] = (r_acc == ref_mem[ea(f, ind, 0)]);
                t_st = "R8 compare";
            end
            4'd6: begin r_pc = f; t_pc = "R4 jump"; end
            4'd7: begin r_st[5] = 1'b1; t_st = "R10 enable"; end
            4'd8: begin r_st[5] = 1'b0; t_st = "R10 disable"; end
            default: t_acc = "R4 no-op";
        endcase
        len = 5 + (nops + nres) * (1 + int'(ind))
            + (1 + (nops + nres) * (1 + int'(ind))) * (2 + wait_cycles);
    endtask

    initial begin
        int          cyc, last, ninst, extra, len, mism;
        logic        irq_next, timeout, taken;
        logic [15:0] word;
        string       t_acc, t_st, t_pc, t_len;

        for (int i = 0; i < 256; i++) put(8'(i), 16'h0000);
        // Main program
        put(8'h00, enc(4'd1, 1'b0, 8'h40));
        put(8'h01, enc(4'd2, 1'b0, 8'h41));
        put(8'h02, enc(4'd2, 1'b1, 8'h42));
        put(8'h03, enc(4'd3, 1'b0, 8'h44));
        put(8'h04, enc(4'd4, 1'b0, 8'h45));
        put(8'h05, enc(4'd4, 1'b1, 8'h48));
        put(8'h06, enc(4'd5, 1'b0, 8'h53));
        put(8'h07, enc(4'd5, 1'b0, 8'h40));
        put(8'h08, enc(4'd7, 1'b0, 8'h00));
        put(8'h09, enc(4'd3, 1'b1, 8'h54));
        put(8'h0A, enc(4'd0, 1'b0, 8'h00));
        put(8'h0B, enc(4'd8, 1'b0, 8'h00));
        put(8'h0C, enc(4'd0, 1'b0, 8'h00));
        put(8'h0D, enc(4'd12, 1'b0, 8'h00));
        put(8'h0E, enc(4'd7, 1'b0, 8'h00));
        put(8'h0F, enc(4'd1, 1'b0, 8'h40));
        put(8'h10, enc(4'd6, 1'b0, 8'h0A));
        // Handler
        put(8'h20, enc(4'd1, 1'b0, 8'h56));
        put(8'h21, enc(4'd3, 1'b0, 8'h57));
        put(8'h22, enc(4'd6, 1'b0, 8'h09));
        // Data
        put(8'h40, 16'h7FFF); put(8'h41, 16'h0001);
        put(8'h42, 16'h0043); put(8'h43, 16'h8000);
        put(8'h45, 16'h0003); put(8'h46, 16'h0005);
        put(8'h48, 16'h0050); put(8'h49, 16'h0051); put(8'h4A, 16'h0052);
        put(8'h50, 16'hFFFF); put(8'h51, 16'h0002);
        put(8'h53, 16'h0001); put(8'h54, 16'h0055); put(8'h56, 16'h1234);
        put(VEC, 16'h0020);

        repeat (3) @(negedge clk);
        check("R1 reset pc", 32'(pc_o), 32'h0);
        check("R1 reset status", 32'(status_o), 32'h0);
        check("R1 reset acc", 32'(acc_o), 32'h0);
        check("R1 reset req", 32'(mem_req), 32'h0);
        check("R1 reset done", 32'(instr_done), 32'h0);

        r_pc = 8'h00; r_acc = 16'h0; r_st = 7'h0;
        prev_taken = 1'b0; prev_ignored = 1'b0;
        irq      = 1'b1;
        irq_next = 1'b1;
        rst      = 1'b0;
        cyc = 0; last = -1; ninst = 0; extra = 0; timeout = 1'b0;

        while (ninst < NINS && !timeout) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                timeout = 1'b1;
                n_chk++; n_bad++;
                $display("FAIL R11 watchdog: actual %0d instructions expected %0d", ninst, NINS);
            end else if (!instr_done) begin
                irq = irq_next;
            end else begin
                t_len = (wait_cycles > 0) ? "R3 length with wait" : "R11 length";
                ref_exec(len, word, t_acc, t_st, t_pc);
                check("R2 instruction register", 32'(ir_o), 32'(word));
                check(t_pc, 32'(pc_o), 32'(r_pc));
                check(t_acc, 32'(acc_o), 32'(r_acc));
                check(t_st, 32'(status_o), 32'(r_st));
                check(t_len, 32'(cyc - last), 32'(len + extra));
                last = cyc;
                ninst++;
                taken        = irq && r_st[5];
                prev_taken   = taken;
                prev_ignored = irq && !r_st[5];
                if (taken) begin
                    ref_mem[STK] = {8'h00, r_pc};
                    r_pc    = ref_mem[VEC][7:0];
                    r_st[5] = 1'b0;
                    r_st[6] = 1'b1;
                    irq_next = 1'b0;
                end
                if (ninst == 20) irq_next = 1'b1;
                wait_cycles = ninst % 3;
                extra = taken ? 3 + 2 * (2 + wait_cycles) : 0;
            end
        end

        repeat (40) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
        check("R6 R9 memory image mismatches", 32'(mism), 32'h0);
        check("R9 stack word", 32'(mem[STK]), 32'(ref_mem[STK]));
        check("R6 dual-add result word", 32'(mem[8'h47]), 32'h0008);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule